// File: doc/BRIEF.md
# Sampling Converter Control Interface Model

This block models the digital side of a successive-approximation converter with a parallel, three-state output. Two active-low control inputs decide what it does. A chip select (`csel_n`) enables the part. A read/convert line (`rdconv`) starts a conversion when low and reads when high. The two inputs are level sensitive. A conversion starts on the first clock edge at which both are low, so whichever of them falls second is the one that triggers it.

A programmable cycle counter stands in for the analog conversion. The value to be "converted" is taken from `sample_in` at the start edge, which represents the hold instant. The ready line (`rdy`) drops for the length of the conversion, and any command that arrives during that time is ignored. The output register takes the new word in the same cycle that `rdy` rises, so a read made during a conversion still returns the previous result.

After each conversion an acquisition timer runs. A conversion started before the timer has run out is marked invalid: the flag travels with the resulting word, and it also sets a sticky error flag that only reset clears. A command still held low when `rdy` rises is the typical cause, because it starts such a conversion straight away.

Top module: `sar_iface_model`

## Requirements
- R1: After synchronous reset, `rdy`=1, `dbus_oe`=0, `word_bad`=0, `acq_err`=0 and the output register holds 0.
- R2: When `rdy`=1, a conversion starts at the first rising edge at which `csel_n`=0 and `rdconv`=0, whichever of the two fell last; `rdy` is 0 after that edge.
- R3: `rdy` stays 0 for exactly CONV_CYCLES clock cycles per conversion.
- R4: Any command seen while `rdy`=0 is ignored and neither lengthens nor restarts the conversion.
- R5: The converted word is `sample_in` as sampled at the start edge. Later changes of `sample_in` have no effect. The output register is loaded in the cycle `rdy` rises.
- R6: `dbus_oe`=1 exactly when `csel_n`=0 and `rdconv`=1; otherwise the bus is high impedance and `dbus_oe`=0.
- R7: A read during a conversion returns the previous conversion's word, unchanged, until `rdy` rises.
- R8: If `csel_n`=0 and `rdconv`=0 are still held when `rdy` rises, a new conversion starts on the next edge and is marked invalid (`word_bad`=1 once it completes, `acq_err`=1).
- R9: Let the last conversion end at the edge where `rdy` rises. A conversion whose start edge comes within ACQ_CYCLES edges of that edge sets `acq_err` and marks its word bad. A start ACQ_CYCLES+1 or more edges later does neither. The first conversion after reset counts as properly acquired.
- R10: `acq_err` stays 1 until reset, even after later valid conversions (which show `word_bad`=0).
- R11: `csel_n`=1 blocks conversion whatever `rdconv` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csel_n | input | 1 | Chip select, active low |
| rdconv | input | 1 | Low: convert command; high: read |
| sample_in | input | DATA_W | Value converted at the start edge |
| rdy | output | 1 | 1 idle, 0 while converting |
| dbus | output | DATA_W | Three-state output data |
| dbus_oe | output | 1 | 1 when `dbus` is driven |
| word_bad | output | 1 | Output word came from an under-acquired conversion |
| acq_err | output | 1 | Sticky under-acquisition flag |

## Verification
The bench builds the block with CONV_CYCLES=8 and ACQ_CYCLES=5. These values keep each conversion short enough to measure to the cycle, and leave room inside the busy window to make a mid-conversion read and send an ignored command. An acquisition window of five cycles lets the bench place back-to-back starts at exactly ACQ_CYCLES and ACQ_CYCLES+1 edges after release, which tests both sides of the acquisition boundary. The held-command re-trigger is reached with a single command that spans two conversions.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAR_WORD_W = 16;

    typedef enum logic [0:0] {
        PH_TRACK   = 1'b0,
        PH_CONVERT = 1'b1
    } phase_t;

    // Width of a down-counter that must hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sar_cmd_decode.sv
module sar_cmd_decode (
    input  logic csel_n,
    input  logic rdconv,
    output logic start_req,
    output logic bus_en
);
    // Level-sensitive: the inputs are OR-combined (active low), so a
    // command exists only while both are low.
    assign start_req = ~(csel_n | rdconv);
    assign bus_en    = ~csel_n & rdconv;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    output logic busy,
    output logic launch,
    output logic finish
);
    import sar_pkg::*;

    localparam int CW = cnt_w(CONV_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CONV_CYCLES - 1);

    phase_t        phase;
    logic [CW-1:0] remain;

    assign busy   = (phase == PH_CONVERT);
    assign launch = (phase == PH_TRACK) && start_req;
    assign finish = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_TRACK;
            remain <= '0;
        end else if (launch) begin
            phase  <= PH_CONVERT;
            remain <= LOAD_VAL;
        end else if (finish) begin
            phase  <= PH_TRACK;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQ_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic finish,
    output logic acq_short
);
    import sar_pkg::*;

    generate
        if (ACQ_CYCLES < 1) begin : g_none
            assign acq_short = 1'b0;
        end else begin : g_timer
            localparam int AW = cnt_w(ACQ_CYCLES);
            logic [AW-1:0] acq_left;

            always_ff @(posedge clk) begin
                if (rst)
                    acq_left <= '0;
                else if (finish)
                    acq_left <= AW'(ACQ_CYCLES);
                else if (acq_left != '0)
                    acq_left <= acq_left - 1'b1;
            end

            assign acq_short = (acq_left != '0);
        end
    endgenerate
endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              finish,
    input  logic              acq_short,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] out_code,
    output logic              out_bad,
    output logic              sticky_err
);
    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic              bad;
    } conv_rec_t;

    conv_rec_t held_rec;
    conv_rec_t out_rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_rec   <= '0;
            out_rec    <= '0;
            sticky_err <= 1'b0;
        end else begin
            if (launch) begin
                held_rec.code <= sample_in;
                held_rec.bad  <= acq_short;
                if (acq_short)
                    sticky_err <= 1'b1;
            end
            if (finish)
                out_rec <= held_rec;
        end
    end

    assign out_code = out_rec.code;
    assign out_bad  = out_rec.bad;
endmodule

// File: rtl/sar_iface_model.sv
module sar_iface_model #(
    parameter int DATA_W      = sar_pkg::SAR_WORD_W,
    parameter int CONV_CYCLES = 20,
    parameter int ACQ_CYCLES  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csel_n,
    input  logic              rdconv,
    input  logic [DATA_W-1:0] sample_in,
    output logic              rdy,
    output logic [DATA_W-1:0] dbus,
    output logic              dbus_oe,
    output logic              word_bad,
    output logic              acq_err
);
    logic start_req;
    logic busy;
    logic launch;
    logic finish;
    logic acq_short;
    logic [DATA_W-1:0] out_code;

    sar_cmd_decode u_dec (
        .csel_n    (csel_n),
        .rdconv    (rdconv),
        .start_req (start_req),
        .bus_en    (dbus_oe)
    );

    sar_sequencer #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .busy      (busy),
        .launch    (launch),
        .finish    (finish)
    );

    sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
        .clk       (clk),
        .rst       (rst),
        .finish    (finish),
        .acq_short (acq_short)
    );

    sar_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .finish     (finish),
        .acq_short  (acq_short),
        .sample_in  (sample_in),
        .out_code   (out_code),
        .out_bad    (word_bad),
        .sticky_err (acq_err)
    );

    assign rdy  = ~busy;
    assign dbus = dbus_oe ? out_code : {DATA_W{1'bz}};
endmodule

// File: rtl/sar_iface_checker.sv
module sar_iface_checker #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              csel_n,
    input logic              rdconv,
    input logic              rdy,
    input logic [DATA_W-1:0] dbus,
    input logic              dbus_oe,
    input logic              acq_err
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)
            low_run <= '0;
        else if (!rdy)
            low_run <= low_run + 1;
        else
            low_run <= '0;
    end

    // R2: idle plus both inputs low starts a conversion
    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (rdy && !csel_n && !rdconv) |=> !rdy);

    // R3: busy window never overruns
    assert_len_max_R3: assert property (@(posedge clk) disable iff (rst)
        !rdy |-> (low_run < CONV_CYCLES));

    // R3: busy window has the full length when it ends
    assert_len_end_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> (low_run == CONV_CYCLES));

    // R4: busy only begins from a command seen while idle
    assert_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> $past(!csel_n && !rdconv));

    // R7: bus value frozen during a conversion
    assert_prev_word_R7: assert property (@(posedge clk) disable iff (rst)
        (!rdy && dbus_oe && $past(!rdy && dbus_oe)) |-> $stable(dbus));

    // R8: a command held through release re-triggers at once
    assert_retrigger_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(rdy) && !csel_n && !rdconv) |=> !rdy);

    // R10: error flag is sticky
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        acq_err |=> acq_err);

    // R11: deselected part stays idle
    assert_desel_R11: assert property (@(posedge clk) disable iff (rst)
        (rdy && csel_n) |=> rdy);
endmodule

bind sar_iface_model sar_iface_checker #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .csel_n  (csel_n),
    .rdconv  (rdconv),
    .rdy     (rdy),
    .dbus    (dbus),
    .dbus_oe (dbus_oe),
    .acq_err (acq_err)
);

// File: tb/sar_iface_model_bench.sv
module sar_iface_model_bench;
    localparam int DW   = 16;
    localparam int CONV = 8;
    localparam int ACQ  = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csel_n = 1'b1;
    logic          rdconv = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic          rdy;
    logic [DW-1:0] dbus;
    logic          dbus_oe;
    logic          word_bad;
    logic          acq_err;

    int n_chk = 0;
    int n_err = 0;

    sar_iface_model #(.DATA_W(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) u_sar_iface_model (
        .clk(clk), .rst(rst), .csel_n(csel_n), .rdconv(rdconv),
        .sample_in(sample_in), .rdy(rdy), .dbus(dbus), .dbus_oe(dbus_oe),
        .word_bad(word_bad), .acq_err(acq_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; csel_n = 1'b1; rdconv = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    // Read at the current negedge; restores deselect afterwards
    task automatic read_word(input string req, input logic [DW-1:0] exp);
        csel_n = 1'b0; rdconv = 1'b1;
        #1;
        chk({req, " bus enabled for read"}, 32'(dbus_oe), 32'd1);
        chk({req, " read value"}, 32'(dbus), 32'(exp));
        csel_n = 1'b1;
        #1;
    endtask

    // Pulse a command, change sample after start, count busy cycles
    task automatic convert(input logic [DW-1:0] d, output int n);
        sample_in = d; csel_n = 1'b0; rdconv = 1'b0;
        @(negedge clk);
        n = rdy ? 0 : 1;
        csel_n = 1'b1; rdconv = 1'b1;
        sample_in = ~d;
        while (!rdy && n < 100) begin
            @(negedge clk);
            if (!rdy) n++;
        end
    endtask

    task automatic t_reset();
        chk("R1 rdy after reset", 32'(rdy), 32'd1);
        chk("R1 bus off after reset", 32'(dbus_oe), 32'd0);
        chk("R1 word_bad after reset", 32'(word_bad), 32'd0);
        chk("R1 acq_err after reset", 32'(acq_err), 32'd0);
        read_word("R1", '0);
    endtask

    task automatic t_basic();
        int n;
        // R11: rdconv low alone while deselected
        csel_n = 1'b1; rdconv = 1'b0; sample_in = 16'h1234;
        cyc(3);
        chk("R11 deselected stays idle", 32'(rdy), 32'd1);
        chk("R6 bus off when rdconv low", 32'(dbus_oe), 32'd0);
        // R2: chip select falls last
        csel_n = 1'b0;
        @(negedge clk);
        chk("R2 start on csel_n falling last", 32'(rdy), 32'd0);
        chk("R6 bus off during convert cmd", 32'(dbus_oe), 32'd0);
        n = 1;
        csel_n = 1'b1; rdconv = 1'b1; sample_in = 16'hFFFF;
        chk("R6 bus off when deselected", 32'(dbus_oe), 32'd0);
        while (!rdy && n < 100) begin
            @(negedge clk);
            if (!rdy) n++;
        end
        chk("R3 busy length", 32'(n), 32'(CONV));
        read_word("R5 held sample", 16'h1234);
        chk("R9 first conversion after reset valid", 32'(word_bad), 32'd0);
        chk("R9 no acq_err after reset", 32'(acq_err), 32'd0);
    endtask

    task automatic t_order_ignore();
        int n;
        cyc(ACQ + 2);
        sample_in = 16'hA5C3; csel_n = 1'b0; rdconv = 1'b1;
        @(negedge clk);
        rdconv = 1'b0;               // rdconv falls last
        @(negedge clk);
        chk("R2 start on rdconv falling last", 32'(rdy), 32'd0);
        n = 1;
        rdconv = 1'b1; sample_in = 16'h0F0F;
        #1;
        chk("R7 read during conversion", 32'(dbus), 32'h1234);
        @(negedge clk);
        if (!rdy) n++;
        rdconv = 1'b0;               // command during busy: ignored
        @(negedge clk);
        if (!rdy) n++;
        rdconv = 1'b1;
        #1;
        chk("R7 previous word after ignored command", 32'(dbus), 32'h1234);
        csel_n = 1'b1;
        while (!rdy && n < 100) begin
            @(negedge clk);
            if (!rdy) n++;
        end
        chk("R4 command during busy ignored", 32'(n), 32'(CONV));
        read_word("R5 new word after release", 16'hA5C3);
        chk("R9 spaced start valid", 32'(word_bad), 32'd0);
    endtask

    task automatic t_retrigger();
        int n;
        cyc(ACQ + 2);
        sample_in = 16'h5555; csel_n = 1'b0; rdconv = 1'b0;
        @(negedge clk);
        n = 0;
        while (!rdy && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R8 first word flag clean", 32'(word_bad), 32'd0);
        sample_in = 16'h6789;
        @(negedge clk);
        chk("R8 held command re-triggers", 32'(rdy), 32'd0);
        chk("R8 acq_err set by re-trigger", 32'(acq_err), 32'd1);
        csel_n = 1'b1; rdconv = 1'b1;
        n = 0;
        while (!rdy && n < 100) begin
            @(negedge clk);
            n++;
        end
        read_word("R8 re-triggered word", 16'h6789);
        chk("R8 re-triggered word flagged bad", 32'(word_bad), 32'd1);
    endtask

    task automatic t_sticky();
        int n;
        cyc(ACQ + 2);
        convert(16'hBEEF, n);
        chk("R10 valid word after error", 32'(word_bad), 32'd0);
        chk("R10 acq_err still set", 32'(acq_err), 32'd1);
        read_word("R10", 16'hBEEF);
        do_reset();
        chk("R1 reset clears acq_err", 32'(acq_err), 32'd0);
    endtask

    task automatic t_window();
        int n;
        do_reset();
        convert(16'h1111, n);
        cyc(ACQ);
        convert(16'h2222, n);
        chk("R9 start ACQ+1 edges after release valid", 32'(word_bad), 32'd0);
        chk("R9 no acq_err at boundary", 32'(acq_err), 32'd0);
        read_word("R9", 16'h2222);
        do_reset();
        convert(16'h3333, n);
        cyc(ACQ - 1);
        convert(16'h4444, n);
        chk("R9 start ACQ edges after release flagged", 32'(word_bad), 32'd1);
        chk("R9 acq_err inside window", 32'(acq_err), 32'd1);
        chk("R3 busy length short-acquired", 32'(n), 32'(CONV));
        read_word("R9", 16'h4444);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_basic();
        t_order_ignore();
        t_retrigger();
        t_sticky();
        t_window();
        cyc(2);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule